// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Arbiter

This block holds a small set of transmit mailboxes for a CAN controller and decides which loaded mailbox is offered next to the bit engine. Each mailbox has a mode field, a 4-bit priority, an identifier with an extended-format flag, a data length code, a remote-request flag and eight data bytes. A host write port loads these fields. A trigger write to a mailbox's command register marks that mailbox as waiting.

Whenever the transmitter is idle, the arbiter takes the waiting mailbox with the smallest priority value. On a tie it takes the lowest index. It latches that mailbox's frame onto the transmitter outputs and pulses a start strobe. The transmitter later answers with a done or an abort pulse. The arbiter then releases the mailbox, records the outcome in the mailbox status flags and raises the mailbox's interrupt flag.

Top module: `can_txarb`

## Requirements
- R1: After reset every mailbox reads ready=1, aborted=0 and interrupt=0, the mode is disabled (0), and `tx_start_o` is low.
- R2: A write with `wr_sel_i`=4 (command) and bit 23 set is accepted only when that mailbox's mode field is 3 (transmit) and the mailbox is ready. Acceptance clears ready at the next edge. A trigger to a non-transmit mailbox, or to one that is not ready, changes nothing.
- R3: Among waiting mailboxes, the one with the smallest priority value wins, where 0 is the highest priority. On equal priority the lowest mailbox index wins.
- R4: With the transmitter idle and at least one mailbox waiting, `tx_start_o` pulses for one cycle at the next edge, and `tx_mb_o` gives the chosen index. The chosen mailbox stays not-ready until its outcome arrives.
- R5: While a frame is with the transmitter, no new start is issued and the chosen index does not change, even if a mailbox with a better priority starts waiting. After the outcome, the next start comes one edge later.
- R6: `tx_done_i` while busy sets ready=1, clears aborted and sets interrupt for the current mailbox.
- R7: `tx_abort_i` while busy, with `tx_done_i` low, sets ready=1, aborted=1 and interrupt=1 for the current mailbox. Outcome pulses while idle are ignored.
- R8: An identifier write (`wr_sel_i`=1) takes effect only while the mailbox mode is 0 (disabled). Bits 28:0 hold the identifier and bit 29 holds the extended flag.
- R9: Mode writes (`wr_sel_i`=0) load the mode from bits 26:24 and the priority from bits 19:16. An accepted trigger loads the DLC from bits 19:16 and RTR from bit 20. `wr_sel_i`=2 and 3 load data bytes 0-3 (`tx_data_o[31:0]`) and 4-7 (`tx_data_o[63:32]`). The frame outputs show the chosen mailbox's fields as they stood at the start edge.
- R10: An accepted trigger clears that mailbox's interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host register write strobe |
| wr_mb_i | input | IDX_W | Target mailbox index |
| wr_sel_i | input | 3 | Register select: 0 mode, 1 identifier, 2 data low, 3 data high, 4 command |
| wr_data_i | input | 32 | Write data |
| mb_ready_o | output | NUM_MB | Per-mailbox ready flag |
| mb_abort_o | output | NUM_MB | Per-mailbox aborted flag |
| mb_irq_o | output | NUM_MB | Per-mailbox interrupt flag |
| tx_start_o | output | 1 | One-cycle start strobe to the transmitter |
| tx_mb_o | output | IDX_W | Index of the mailbox being sent |
| tx_id_o | output | 29 | Frame identifier |
| tx_ide_o | output | 1 | Extended identifier flag |
| tx_rtr_o | output | 1 | Remote request flag |
| tx_dlc_o | output | 4 | Data length code |
| tx_data_o | output | 64 | Data bytes, byte 0 in bits 7:0 |
| tx_done_i | input | 1 | Transmitter reports completion |
| tx_abort_i | input | 1 | Transmitter reports abort |

## Verification
A wrong waiting flag or a wrong busy state shows up within one cycle as a start strobe that comes early, late or twice, or as a ready flag with the wrong value. A flaw in the priority comparison is hidden until two mailboxes wait at once. It then shows on `tx_mb_o` at the start edge, so the stimulus stacks waiting mailboxes with equal and with different priorities. Stale or wrongly gated register contents appear only on the frame outputs at a later start. Each start is therefore compared field by field against the expected frame.

// File: rtl/can_txarb_pkg.sv
package can_txarb_pkg;
  localparam int unsigned SEL_MODE = 0;
  localparam int unsigned SEL_ID   = 1;
  localparam int unsigned SEL_DLO  = 2;
  localparam int unsigned SEL_DHI  = 3;
  localparam int unsigned SEL_CMD  = 4;

  localparam logic [2:0] MODE_OFF = 3'd0;
  localparam logic [2:0] MODE_TX  = 3'd3;

  localparam int unsigned MODE_LSB = 24;
  localparam int unsigned PRIO_LSB = 16;
  localparam int unsigned DLC_LSB  = 16;
  localparam int unsigned RTR_BIT  = 20;
  localparam int unsigned GO_BIT   = 23;
  localparam int unsigned IDE_BIT  = 29;

  typedef struct packed {
    logic        ide;
    logic [28:0] id;
    logic        rtr;
    logic [3:0]  dlc;
    logic [63:0] data;
  } frame_t;
endpackage

// File: rtl/can_txarb_mb.sv
module can_txarb_mb
  import can_txarb_pkg::*;
#(
  parameter int unsigned PRIO_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [31:0]       wr_data_i,
  input  logic              launch_i,
  input  logic              inflight_i,
  input  logic              done_i,
  input  logic              abt_i,
  output logic              pend_o,
  output logic [PRIO_W-1:0] prio_o,
  output frame_t            frame_o,
  output logic              ready_o,
  output logic              abort_o,
  output logic              irq_o
);
  logic [2:0]        mode_q;
  logic [PRIO_W-1:0] prio_q;
  frame_t            frm_q;
  logic              pend_q, abort_q, irq_q;
  logic              trig;

  assign ready_o = ~pend_q & ~inflight_i;
  assign trig    = wr_hit_i && (wr_sel_i == 3'(SEL_CMD)) && wr_data_i[GO_BIT]
                   && (mode_q == MODE_TX) && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_OFF;
      prio_q  <= '0;
      frm_q   <= '0;
      pend_q  <= 1'b0;
      abort_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_hit_i) begin
        case (wr_sel_i)
          3'(SEL_MODE): begin
            mode_q <= wr_data_i[MODE_LSB +: 3];
            prio_q <= wr_data_i[PRIO_LSB +: PRIO_W];
          end
          3'(SEL_ID): if (mode_q == MODE_OFF) begin
            frm_q.ide <= wr_data_i[IDE_BIT];
            frm_q.id  <= wr_data_i[28:0];
          end
          3'(SEL_DLO): frm_q.data[31:0]  <= wr_data_i;
          3'(SEL_DHI): frm_q.data[63:32] <= wr_data_i;
          default: ;
        endcase
      end
      if (trig) begin
        pend_q    <= 1'b1;
        frm_q.dlc <= wr_data_i[DLC_LSB +: 4];
        frm_q.rtr <= wr_data_i[RTR_BIT];
        irq_q     <= 1'b0;
      end
      if (launch_i) pend_q <= 1'b0;
      if (done_i) begin
        abort_q <= 1'b0;
        irq_q   <= 1'b1;
      end else if (abt_i) begin
        abort_q <= 1'b1;
        irq_q   <= 1'b1;
      end
    end
  end

  assign pend_o  = pend_q;
  assign prio_o  = prio_q;
  assign frame_o = frm_q;
  assign abort_o = abort_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/can_txarb_pick.sv
module can_txarb_pick #(
  parameter int unsigned NUM_MB = 4,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
  input  logic [NUM_MB-1:0]             pend_i,
  input  logic [NUM_MB-1:0][PRIO_W-1:0] prio_i,
  output logic                          any_o,
  output logic [IDX_W-1:0]              win_o
);
  logic [PRIO_W-1:0] best;

  // strict less-than keeps the lowest index on a tie
  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    best  = '1;
    for (int i = 0; i < NUM_MB; i++) begin
      if (pend_i[i] && (!any_o || prio_i[i] < best)) begin
        any_o = 1'b1;
        win_o = IDX_W'(i);
        best  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/can_txarb.sv
module can_txarb
  import can_txarb_pkg::*;
#(
  parameter int unsigned NUM_MB = 4,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_mb_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [31:0]       wr_data_i,
  output logic [NUM_MB-1:0] mb_ready_o,
  output logic [NUM_MB-1:0] mb_abort_o,
  output logic [NUM_MB-1:0] mb_irq_o,
  output logic              tx_start_o,
  output logic [IDX_W-1:0]  tx_mb_o,
  output logic [28:0]       tx_id_o,
  output logic              tx_ide_o,
  output logic              tx_rtr_o,
  output logic [3:0]        tx_dlc_o,
  output logic [63:0]       tx_data_o,
  input  logic              tx_done_i,
  input  logic              tx_abort_i
);
  logic [NUM_MB-1:0]             pend;
  logic [NUM_MB-1:0][PRIO_W-1:0] prio;
  frame_t                        frames [NUM_MB];
  logic                          any_pend, launch;
  logic [IDX_W-1:0]              win;
  logic                          busy_q, start_q;
  logic [IDX_W-1:0]              cur_q;
  frame_t                        frm_q;

  can_txarb_pick #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W)) u_pick (
    .pend_i (pend),
    .prio_i (prio),
    .any_o  (any_pend),
    .win_o  (win)
  );

  assign launch = !busy_q && any_pend;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    logic sel_cur;
    assign sel_cur = busy_q && (cur_q == IDX_W'(g));
    can_txarb_mb #(.PRIO_W(PRIO_W)) u_mb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_hit_i   (wr_en_i && (wr_mb_i == IDX_W'(g))),
      .wr_sel_i   (wr_sel_i),
      .wr_data_i  (wr_data_i),
      .launch_i   (launch && (win == IDX_W'(g))),
      .inflight_i (sel_cur),
      .done_i     (sel_cur && tx_done_i),
      .abt_i      (sel_cur && !tx_done_i && tx_abort_i),
      .pend_o     (pend[g]),
      .prio_o     (prio[g]),
      .frame_o    (frames[g]),
      .ready_o    (mb_ready_o[g]),
      .abort_o    (mb_abort_o[g]),
      .irq_o      (mb_irq_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      cur_q   <= '0;
      frm_q   <= '0;
    end else begin
      start_q <= launch;
      if (launch) begin
        busy_q <= 1'b1;
        cur_q  <= win;
        frm_q  <= frames[win];
      end else if (busy_q && (tx_done_i || tx_abort_i)) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign tx_start_o = start_q;
  assign tx_mb_o    = cur_q;
  assign tx_id_o    = frm_q.id;
  assign tx_ide_o   = frm_q.ide;
  assign tx_rtr_o   = frm_q.rtr;
  assign tx_dlc_o   = frm_q.dlc;
  assign tx_data_o  = frm_q.data;
endmodule

// File: rtl/can_txarb_chk.sv
module can_txarb_chk #(
  parameter int unsigned NUM_MB = 4,
  localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_q,
  input logic              tx_start_o,
  input logic [IDX_W-1:0]  tx_mb_o,
  input logic [NUM_MB-1:0] mb_ready_o,
  input logic [NUM_MB-1:0] mb_abort_o,
  input logic [NUM_MB-1:0] mb_irq_o,
  input logic              tx_done_i,
  input logic              tx_abort_i
);
  a_r5_single_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);

  a_r4_chosen_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> !mb_ready_o[tx_mb_o]);

  a_r5_index_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tx_start_o) |-> $stable(tx_mb_o));

  a_r6_done_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tx_done_i) |=>
      (mb_ready_o[$past(tx_mb_o)] && mb_irq_o[$past(tx_mb_o)] && !mb_abort_o[$past(tx_mb_o)]));

  a_r7_abort_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tx_done_i && tx_abort_i) |=>
      (mb_ready_o[$past(tx_mb_o)] && mb_irq_o[$past(tx_mb_o)] && mb_abort_o[$past(tx_mb_o)]));
endmodule

bind can_txarb can_txarb_chk #(.NUM_MB(NUM_MB)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_q     (busy_q),
  .tx_start_o (tx_start_o),
  .tx_mb_o    (tx_mb_o),
  .mb_ready_o (mb_ready_o),
  .mb_abort_o (mb_abort_o),
  .mb_irq_o   (mb_irq_o),
  .tx_done_i  (tx_done_i),
  .tx_abort_i (tx_abort_i)
);

// File: tb/can_txarb_tb.sv
module can_txarb_tb;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_mb = '0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        done = 1'b0, abt = 1'b0;
  logic [N-1:0] rdy_o, abo_o, irq_o;
  logic        start_o, ide_o, rtr_o;
  logic [1:0]  mb_o;
  logic [28:0] id_o;
  logic [3:0]  dlc_o;
  logic [63:0] data_o;

  always #2 clk = ~clk;

  can_txarb u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_mb_i(wr_mb),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .mb_ready_o(rdy_o),
    .mb_abort_o(abo_o), .mb_irq_o(irq_o), .tx_start_o(start_o),
    .tx_mb_o(mb_o), .tx_id_o(id_o), .tx_ide_o(ide_o), .tx_rtr_o(rtr_o),
    .tx_dlc_o(dlc_o), .tx_data_o(data_o), .tx_done_i(done), .tx_abort_i(abt)
  );

  int checks = 0, fails = 0;

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_mode[N], m_prio[N], m_id[N], m_ide[N], m_rtr[N], m_dlc[N];
  int m_pend[N], m_abo[N], m_irq[N];
  longint unsigned m_data[N];
  int m_busy, m_cur, m_start;
  longint unsigned e_data;
  int e_id, e_ide, e_rtr, e_dlc;

  function automatic int m_ready(int i);
    return (!m_pend[i] && !(m_busy && m_cur == i)) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_mode[i] = 0; m_prio[i] = 0; m_id[i] = 0; m_ide[i] = 0; m_rtr[i] = 0;
        m_dlc[i] = 0; m_pend[i] = 0; m_abo[i] = 0; m_irq[i] = 0; m_data[i] = 0;
      end
      m_busy = 0; m_cur = 0; m_start = 0;
    end else begin
      int rd[N];
      int best;
      for (int i = 0; i < N; i++) rd[i] = m_ready(i);
      m_start = 0;
      if (m_busy) begin
        if (done) begin m_abo[m_cur] = 0; m_irq[m_cur] = 1; m_busy = 0; end
        else if (abt) begin m_abo[m_cur] = 1; m_irq[m_cur] = 1; m_busy = 0; end
      end else begin
        best = -1;
        for (int i = 0; i < N; i++)
          if (m_pend[i] && (best < 0 || m_prio[i] < m_prio[best])) best = i;
        if (best >= 0) begin
          m_busy = 1; m_cur = best; m_pend[best] = 0; m_start = 1;
          e_id = m_id[best]; e_ide = m_ide[best]; e_rtr = m_rtr[best];
          e_dlc = m_dlc[best]; e_data = m_data[best];
        end
      end
      if (wr_en) begin
        case (wr_sel)
          3'd0: begin m_mode[wr_mb] = int'(wr_data[26:24]); m_prio[wr_mb] = int'(wr_data[19:16]); end
          3'd1: if (m_mode[wr_mb] == 0) begin m_id[wr_mb] = int'(wr_data[28:0]); m_ide[wr_mb] = int'(wr_data[29]); end
          3'd2: m_data[wr_mb][31:0] = wr_data;
          3'd3: m_data[wr_mb][63:32] = wr_data;
          3'd4: if (wr_data[23] && m_mode[wr_mb] == 3 && rd[wr_mb]) begin
            m_pend[wr_mb] = 1; m_dlc[wr_mb] = int'(wr_data[19:16]);
            m_rtr[wr_mb] = int'(wr_data[20]); m_irq[wr_mb] = 0;
          end
          default: ;
        endcase
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        chk($sformatf("R2/R4/R6 ready mb%0d", i), rdy_o[i], m_ready(i));
        chk($sformatf("R7 abort mb%0d", i), abo_o[i], m_abo[i]);
        chk($sformatf("R6/R10 irq mb%0d", i), irq_o[i], m_irq[i]);
      end
      chk("R4/R5 start", start_o, m_start);
      if (m_start) begin
        chk("R3 chosen index", mb_o, m_cur);
        chk("R8/R9 id", id_o, e_id);
        chk("R8/R9 ide", ide_o, e_ide);
        chk("R9 rtr", rtr_o, e_rtr);
        chk("R9 dlc", dlc_o, e_dlc);
        chk("R9 data", data_o, e_data);
      end
    end
  end

  task automatic wr(int mb, int sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_mb = 2'(mb); wr_sel = 3'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_tx(bit is_abort);
    @(negedge clk);
    if (is_abort) abt = 1'b1; else done = 1'b1;
    @(negedge clk);
    abt = 1'b0; done = 1'b0;
  endtask

  function automatic logic [31:0] mode_w(int mode, int prio);
    return (32'(mode) << 24) | (32'(prio) << 16);
  endfunction

  function automatic logic [31:0] go_w(int dlc, bit rtr);
    return 32'h0080_0000 | (32'(dlc) << 16) | (32'(rtr) << 20);
  endfunction

  int cyc = 0;
  bit timed_out = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !timed_out) begin
      timed_out = 1;
      fails++; checks++;
      $display("FAIL watchdog act=%0d exp<=100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1: reset state
    chk("R1 ready", rdy_o, 4'hf);
    chk("R1 abort", abo_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 start", start_o, 0);
    // R8: identifiers loaded while disabled; R9 data words
    for (int i = 0; i < N; i++) begin
      wr(i, 1, 32'h2000_0000 * (i % 2) | 32'(32'h0123_400 + i));
      wr(i, 2, 32'hA0B0_C000 + 32'(i));
      wr(i, 3, 32'h1122_3300 + 32'(i));
    end
    wr(0, 0, mode_w(3, 5));
    wr(1, 0, mode_w(3, 2));
    wr(2, 0, mode_w(3, 2));
    wr(3, 0, mode_w(3, 9));
    // R3: stack triggers; tie on prio 2 goes to mb1 before mb2
    wr(0, 4, go_w(8, 0));
    wr(1, 4, go_w(3, 1));
    wr(2, 4, go_w(5, 0));
    wr(3, 4, go_w(1, 0));
    // R2: trigger on a waiting mailbox ignored
    wr(3, 4, go_w(7, 1));
    for (int k = 0; k < 4; k++) begin
      idle(2);
      finish_tx(0); // R6
    end
    idle(3);
    // R7: outcome pulses while idle ignored
    finish_tx(1);
    finish_tx(0);
    // R8: identifier write in transmit mode ignored
    wr(0, 1, 32'h1555_5555);
    wr(0, 4, go_w(2, 0)); // R10 clears irq
    idle(2);
    finish_tx(1); // R7 abort
    idle(2);
    // R8: disable, rewrite id, re-enable with new prio
    wr(0, 0, mode_w(0, 0));
    wr(0, 1, 32'h1555_5555);
    wr(0, 0, mode_w(3, 1));
    // R2: trigger on disabled mailbox ignored
    wr(3, 0, mode_w(0, 9));
    wr(3, 4, go_w(4, 0));
    idle(3);
    // R5: lower-priority frame in flight, better one must wait
    wr(2, 0, mode_w(3, 14));
    wr(2, 4, go_w(6, 0));
    wr(0, 4, go_w(8, 1));
    wr(1, 4, go_w(2, 0));
    idle(4);
    finish_tx(0);
    idle(2);
    finish_tx(0);
    idle(2);
    finish_tx(1);
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule